// File: doc/BRIEF.md
# Blocking Write-Back Cache Controller

This block is a direct-mapped data cache that sits between a processor port and a slower memory port. It serves one processor access at a time, and the processor waits until its access completes. The cache keeps a tag, a valid bit and a dirty bit for every line, and a data array next to them. Each line holds `WORDS_PER_LINE` words. Stores that hit update only the cache and mark the line modified. A modified line reaches memory only when another block evicts it.

A four-state sequencer does the work: idle, tag compare, victim write-back and line fetch. On a miss to a modified line, the old line is written back to memory first. The missing line is then fetched. When the fetch finishes, the sequencer goes back to tag compare, so every miss ends as an ordinary hit. The memory port moves one whole line per handshake. Its request stays on the port until memory asserts ready. With the default parameters the cache holds 1024 lines of four 32-bit words, which is 16 KB.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset, `cpu_ready` and `mem_valid` are low and every line is invalid, so the first access to any line goes to memory.
- R2: A 32-bit byte address splits into tag [31:14], index [13:4], word select [3:2] and ignored byte bits [1:0]. Word k of a line sits at line bits [32k+31:32k]. Every memory address has its low 4 bits at zero.
- R3: A read that hits raises `cpu_ready` for one cycle, in the cycle after the request is accepted. It returns the addressed word on `cpu_rdata` and makes no memory request.
- R4: A write that hits completes with the same timing as a read hit. It replaces only the addressed word and marks the line modified.
- R5: A miss on an invalid or unmodified line spends one compare cycle. It then reads memory at `{request tag, index, 0}` with `mem_rw` low and does no write-back.
- R6: A miss on a modified line first writes the whole stored line to `{stored tag, index, 0}` with `mem_rw` high. Only after that write is accepted does the line fetch start.
- R7: After a fetch completes, the controller returns to tag compare and finishes the access as a hit. The filled line is unmodified, so evicting it later causes no write-back.
- R8: A write miss fetches the line, then merges the new word into it and marks the line modified.
- R9: While `mem_valid` is high and `mem_ready` is low, the memory request (valid, direction, address) stays unchanged.
- R10: `cpu_ready` is a single-cycle pulse per access and is never high while a memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_rw | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, meaningful while `cpu_ready` is high |
| cpu_ready | output | 1 | Access complete |
| mem_valid | output | 1 | Memory request present |
| mem_rw | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned memory byte address |
| mem_wdata | output | 128 | Line written back |
| mem_rdata | input | 128 | Line returned by memory |
| mem_ready | input | 1 | Memory transfer complete |

## Verification
The bench sends addresses that share an index but differ in tag, so that evictions happen in a controlled order. A design that skips the write-back of a modified victim would return stale data on the next read of the evicted line. A design that used the requested tag instead of the stored tag would put the old line at the wrong memory address. The bench also writes a word and then reads its neighbours in the same line; a lane-select error would corrupt those neighbours. It covers index 0, the last index with the largest tag, and a write miss that is later evicted, because a fill that left the line modified, or a merge that the fill overwrote, would show up on the memory port or in the returned data.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_WB   = 2'd2,
    ST_FILL = 2'd3
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int LINES = 1024,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag_o,
  output logic             valid_o,
  output logic             dirty_o,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty
);
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  // state bits reset; the tag array does not need to
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[idx] <= fill_tag;
  end

  assign tag_o   = tag_mem[idx];
  assign valid_o = valid_q[idx];
  assign dirty_o = dirty_q[idx];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int LINES  = 1024,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  output logic [LINE_W-1:0] line_o,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              word_we,
  input  logic [WSEL_W-1:0] wsel,
  input  logic [WORD_W-1:0] word_data
);
  // one storage lane per word so a store touches a single lane
  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    logic [WORD_W-1:0] lane_mem [LINES];
    logic              lane_hit;
    assign lane_hit = word_we && (wsel == WSEL_W'(w));
    always_ff @(posedge clk) begin
      if (fill_en)       lane_mem[idx] <= fill_line[w*WORD_W +: WORD_W];
      else if (lane_hit) lane_mem[idx] <= word_data;
    end
    assign line_o[w*WORD_W +: WORD_W] = lane_mem[idx];
  end
endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
  import wbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_valid,
  input  logic       hit,
  input  logic       victim_dirty,
  input  logic       mem_ready,
  output wbc_state_e state_o,
  output logic       accept,
  output logic       cpu_ready,
  output logic       mem_valid,
  output logic       mem_rw,
  output logic       fill_en,
  output logic       hit_evt,
  output logic       miss_evt,
  output logic       wb_done_evt
);
  wbc_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cpu_valid) state_d = ST_CMP;
      ST_CMP: begin
        if (hit)               state_d = ST_IDLE;
        else if (victim_dirty) state_d = ST_WB;
        else                   state_d = ST_FILL;
      end
      ST_WB:   if (mem_ready) state_d = ST_FILL;
      ST_FILL: if (mem_ready) state_d = ST_CMP;
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_o     = state_q;
  assign accept      = (state_q == ST_IDLE) && cpu_valid;
  assign hit_evt     = (state_q == ST_CMP) && hit;
  assign miss_evt    = (state_q == ST_CMP) && !hit;
  assign wb_done_evt = (state_q == ST_WB) && mem_ready;
  assign fill_en     = (state_q == ST_FILL) && mem_ready;
  assign cpu_ready   = hit_evt;
  assign mem_valid   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_rw      = (state_q == ST_WB);
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int WORD_W         = 32,
  parameter int WORDS_PER_LINE = 4,
  parameter int LINES          = 1024,
  localparam int BYTE_OFF_W = $clog2(WORD_W / 8),
  localparam int WSEL_W     = $clog2(WORDS_PER_LINE),
  localparam int OFF_W      = BYTE_OFF_W + WSEL_W,
  localparam int IDX_W      = $clog2(LINES),
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W     = WORDS_PER_LINE * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_rw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  // address arithmetic
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [WSEL_W-1:0] addr_wsel(input logic [ADDR_W-1:0] a);
    return a[BYTE_OFF_W +: WSEL_W];
  endfunction
  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction
  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] l,
                                                  input logic [WSEL_W-1:0] s);
    return l[s*WORD_W +: WORD_W];
  endfunction

  // latched request
  logic              req_rw;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic [WORD_W-1:0] req_wdata;

  // named internal events
  wbc_state_e        state;
  logic              accept;
  logic              hit;
  logic              victim_dirty;
  logic              fill_en;
  logic              hit_evt;
  logic              miss_evt;
  logic              wb_done_evt;
  logic              word_we;
  logic [TAG_W-1:0]  stored_tag;
  logic              stored_valid;
  logic              stored_dirty;
  logic [LINE_W-1:0] stored_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_rw    <= 1'b0;
      req_tag   <= '0;
      req_idx   <= '0;
      req_wsel  <= '0;
      req_wdata <= '0;
    end else if (accept) begin
      req_rw    <= cpu_rw;
      req_tag   <= addr_tag(cpu_addr);
      req_idx   <= addr_index(cpu_addr);
      req_wsel  <= addr_wsel(cpu_addr);
      req_wdata <= cpu_wdata;
    end
  end

  assign hit          = stored_valid && (stored_tag == req_tag);
  assign victim_dirty = stored_valid && stored_dirty;
  assign word_we      = hit_evt && req_rw;

  wbc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_valid    (cpu_valid),
    .hit          (hit),
    .victim_dirty (victim_dirty),
    .mem_ready    (mem_ready),
    .state_o      (state),
    .accept       (accept),
    .cpu_ready    (cpu_ready),
    .mem_valid    (mem_valid),
    .mem_rw       (mem_rw),
    .fill_en      (fill_en),
    .hit_evt      (hit_evt),
    .miss_evt     (miss_evt),
    .wb_done_evt  (wb_done_evt)
  );

  wbc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (req_idx),
    .tag_o      (stored_tag),
    .valid_o    (stored_valid),
    .dirty_o    (stored_dirty),
    .fill_en    (fill_en),
    .fill_tag   (req_tag),
    .mark_dirty (word_we)
  );

  wbc_data_store #(.LINES(LINES), .WORDS(WORDS_PER_LINE), .WORD_W(WORD_W)) u_data (
    .clk       (clk),
    .idx       (req_idx),
    .line_o    (stored_line),
    .fill_en   (fill_en),
    .fill_line (mem_rdata),
    .word_we   (word_we),
    .wsel      (req_wsel),
    .word_data (req_wdata)
  );

  assign cpu_rdata = pick_word(stored_line, req_wsel);
  assign mem_wdata = stored_line;
  assign mem_addr  = (state == ST_WB) ? line_base(stored_tag, req_idx)
                                      : line_base(req_tag, req_idx);
endmodule

// File: rtl/wb_cache_ctrl_chk.sv
module wb_cache_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              mem_valid,
  input logic              mem_rw,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              hit_evt,
  input logic              miss_evt,
  input logic              wb_done_evt,
  input logic              fill_en
);
  assert_line_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

  assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> !mem_valid);

  assert_miss_to_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> mem_valid);

  assert_wb_then_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done_evt |=> (mem_valid && !mem_rw && $stable(mem_addr[OFF_W +: IDX_W])));

  assert_fill_to_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !mem_valid);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_rw) && $stable(mem_addr)));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  assert_ready_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_valid);
endmodule

bind wb_cache_ctrl wb_cache_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_ready   (cpu_ready),
  .mem_valid   (mem_valid),
  .mem_rw      (mem_rw),
  .mem_addr    (mem_addr),
  .mem_ready   (mem_ready),
  .hit_evt     (hit_evt),
  .miss_evt    (miss_evt),
  .wb_done_evt (wb_done_evt),
  .fill_en     (fill_en)
);

// File: tb/wb_cache_ctrl_test.sv
module wb_cache_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 2;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_valid = 1'b0;
  logic         cpu_rw = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         mem_valid;
  logic         mem_rw;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_cache_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_rw(mem_rw), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // reference state: latest value of every word, memory contents, line bookkeeping
  logic [31:0]  ref_mem  [logic [31:0]];
  logic [127:0] back_mem [logic [31:0]];
  bit           m_valid  [int];
  logic [17:0]  m_tag    [int];
  bit           m_dirty  [int];

  function automatic logic [31:0] seed_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16]} + 32'h0001_3579;
  endfunction

  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (ref_mem.exists(w)) return ref_mem[w];
    return seed_word(w);
  endfunction

  function automatic logic [127:0] back_rd(input logic [31:0] la);
    logic [127:0] l;
    if (back_mem.exists(la)) return back_mem[la];
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = seed_word(la + 32'(4*k));
    return l;
  endfunction

  function automatic logic [127:0] ref_line(input logic [31:0] la);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = ref_rd(la + 32'(4*k));
    return l;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // memory model: ready after MEM_LAT cycles of a held request
  int lat_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      lat_cnt = 0;
    end else if (mem_valid) begin
      if (lat_cnt == MEM_LAT - 1) begin
        mem_ready = 1'b1;
        lat_cnt = 0;
        if (mem_rw) back_mem[mem_addr] = mem_wdata;
        else        mem_rdata = back_rd(mem_addr);
      end else begin
        mem_ready = 1'b0;
        lat_cnt++;
      end
    end else begin
      mem_ready = 1'b0;
      lat_cnt = 0;
    end
  end

  // one processor access, checked cycle by cycle against the reference
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d);
    int          idx = int'(a[13:4]);
    logic [17:0] tg = a[31:14];
    bit          present = m_valid.exists(idx) && m_valid[idx];
    bit          hit = present && (m_tag[idx] == tg);
    bit          dirty_victim = !hit && present && m_dirty[idx];
    logic [31:0] req_la = {a[31:4], 4'b0000};
    logic [31:0] vic_la = present ? {m_tag[idx], a[13:4], 4'b0000} : 32'h0;
    logic [127:0] vic_line = ref_line(vic_la);
    string       done_req = hit ? (wr ? "R4" : "R3") : (wr ? "R8" : "R7");

    @(negedge clk);
    cpu_valid = 1'b1;
    cpu_rw    = wr;
    cpu_addr  = a;
    cpu_wdata = d;
    chk("R10", "accept-cycle cpu_ready", 128'(cpu_ready), 128'(0));
    chk("R10", "accept-cycle mem_valid", 128'(mem_valid), 128'(0));
    if (!hit) begin
      @(negedge clk);
      chk("R5", "compare-miss cpu_ready", 128'(cpu_ready), 128'(0));
      chk("R5", "compare-miss mem_valid", 128'(mem_valid), 128'(0));
      if (dirty_victim) begin
        for (int k = 0; k < MEM_LAT; k++) begin
          @(negedge clk);
          chk("R6", "writeback mem_valid", 128'(mem_valid), 128'(1));
          chk("R6", "writeback mem_rw", 128'(mem_rw), 128'(1));
          chk("R6", "writeback mem_addr", 128'(mem_addr), 128'(vic_la));
          chk("R6", "writeback mem_wdata", mem_wdata, vic_line);
          chk("R10", "writeback cpu_ready", 128'(cpu_ready), 128'(0));
        end
      end
      for (int k = 0; k < MEM_LAT; k++) begin
        @(negedge clk);
        chk("R5", "fetch mem_valid", 128'(mem_valid), 128'(1));
        chk("R5", "fetch mem_rw", 128'(mem_rw), 128'(0));
        chk("R2", "fetch mem_addr", 128'(mem_addr), 128'(req_la));
        chk("R10", "fetch cpu_ready", 128'(cpu_ready), 128'(0));
      end
    end
    @(negedge clk);
    chk(done_req, "completion cpu_ready", 128'(cpu_ready), 128'(1));
    chk(done_req, "completion mem_valid", 128'(mem_valid), 128'(0));
    if (!wr) chk(done_req, "read data", 128'(cpu_rdata), 128'(ref_rd(a)));
    cpu_valid = 1'b0;
    m_valid[idx] = 1'b1;
    m_tag[idx]   = tg;
    if (!hit) m_dirty[idx] = 1'b0;
    if (wr) begin
      m_dirty[idx] = 1'b1;
      ref_mem[{a[31:2], 2'b00}] = d;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R10", "idle cpu_ready", 128'(cpu_ready), 128'(0));
      chk("R9", "idle mem_valid", 128'(mem_valid), 128'(0));
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset cpu_ready", 128'(cpu_ready), 128'(0));
    chk("R1", "reset mem_valid", 128'(mem_valid), 128'(0));
    rst_n = 1'b1;
    idle(2);

    // R1 R5: cold read misses; R3: hits on same line, byte bits ignored (R2)
    access(0, 32'h0000_0100, 0);
    access(0, 32'h0000_0104, 0);
    access(0, 32'h0000_010E, 0);
    // R4: write hit alters only its word
    access(1, 32'h0000_0104, 32'hDEAD_BEEF);
    access(0, 32'h0000_0104, 0);
    access(0, 32'h0000_0100, 0);
    access(0, 32'h0000_0108, 0);
    idle(3);
    // R6: conflicting tag evicts modified line; R7: clean line evicted without write-back
    access(0, 32'h0000_4100, 0);
    access(0, 32'h0000_0104, 0);
    access(0, 32'h0000_410C, 0);
    // R8: write miss allocates, later evicted and re-read from memory
    access(1, 32'h0000_8208, 32'h1234_5678);
    access(0, 32'h0000_8208, 0);
    access(0, 32'h0000_0208, 0);
    access(0, 32'h0000_8208, 0);
    access(0, 32'h0000_820C, 0);
    // R2 boundaries: index 0, last index with largest tag
    access(0, 32'h0000_0000, 0);
    access(1, 32'hFFFF_FFFC, 32'hA1B2_C3D4);
    access(1, 32'hFFFF_FFF0, 32'h0F0F_0F0F);
    access(0, 32'h0000_3FF0, 0);
    access(0, 32'hFFFF_FFFC, 0);
    access(0, 32'hFFFF_FFF4, 0);

    // mixed traffic over a few conflicting lines
    begin
      logic [31:0] lcg = 32'h1ACE_0001;
      for (int n = 0; n < 120; n++) begin
        logic [31:0] a;
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        a = {12'h000, lcg[27:26], 4'h0, 8'h00, lcg[21:20], 2'b00, lcg[17:16], 2'b00};
        access(lcg[31], a, lcg ^ 32'h5555_AAAA);
        if (lcg[9:8] == 2'b00) idle(1);
      end
    end
    idle(2);
    done = 1;
    report();
    $finish;
  end
endmodule